// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Proxy

This block sits behind a user data register of a test access port and turns one pass through Shift-DR into one SPI flash transaction. It runs entirely on the test clock. While the TAP is shifting, the block looks for a single 1 bit in the TDI stream. Any 0 bits before that bit are discarded. After the 1 it collects a 32-bit length, most significant bit first. Every TDI bit after the length is then forwarded to the flash as one MOSI bit. For each of these bits the block produces one SCK pulse with chip select held low.

The flash's MISO value from each SPI cycle is registered and driven onto TDO one test clock later. A host that leaves one spare bit before its read window therefore sees the read data aligned to byte boundaries. To clock the read bytes out, the host pads the frame with zero MOSI bits. Chip select drops as soon as the programmed number of bits has passed, or when the TAP leaves Shift-DR. Every Capture-DR re-arms the block to hunt for a new marker.

Top module: `jtag_spi_bridge`

## Requirements
- R1: After synchronous reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0 and tdo is 0.
- R2: While the bridge hunts for a marker, shifted 0 bits cause no SPI activity: spi_cs_n stays 1 and spi_sck stays 0.
- R3: The first shifted 1 is the marker. The next 32 shifted bits form the length L, MSB first. No SPI activity occurs during the marker or the length bits.
- R4: The L+1 bits shifted after the length are data bits. During the TCK cycle that follows the edge taking data bit k, spi_cs_n is 0 and spi_mosi equals that bit, in shift order.
- R5: Each data bit yields exactly one SCK pulse. spi_sck is high only during the low phase of TCK in the cycle after the bit is taken, and only while spi_cs_n is 0.
- R6: Shifted bits after the L+1 data bits are ignored: spi_cs_n returns to 1 and spi_sck stays 0.
- R7: tdo is registered. After the edge that takes frame position p, tdo holds the MISO value sampled during the SCK pulse of data bit p-1.
- R8: When shift_en is low during the length or data phase, the transfer aborts. spi_cs_n goes to 1, and further shifted bits cause no SPI activity until the next capture.
- R9: A capture pulse returns the bridge to marker hunting and forces spi_cs_n to 1, so a new frame works after an aborted one.
- R10: An update pulse ends any transfer in progress; spi_cs_n is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | High while the TAP is in Shift-DR with this register selected |
| capture | input | 1 | Capture-DR strobe for this register |
| update | input | 1 | Update-DR strobe for this register |
| tdi | input | 1 | Serial data from the TAP |
| tdo | output | 1 | Registered MISO returned to the TAP |
| spi_sck | output | 1 | SPI clock, inverted TCK gated by the data phase |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench shifts frames with different numbers of leading zeros and different lengths, down to a one-bit transfer. This separates the bridge's marker hunting and length decoding from any fixed frame offset. Each frame carries an asymmetric data word and a distinct MISO pattern from a modelled flash. A bit-order reversal, an off-by-one in the chip-select window, or a wrong TDO latency therefore shows up at a specific frame position. Trailing ones after each transfer show whether excess bits leak to the flash. An aborted frame is closed with an update pulse and then continues shifting ones. It is followed by a clean frame, which shows that the abort holds until capture and that capture fully re-arms the bridge.

// File: rtl/jsb_pkg.sv
// Package: shared types and sizes for the JTAG-to-SPI bridge.
// Assumes: a 32-bit length field, as fixed by the host frame format.
package jsb_pkg;
    localparam int unsigned LEN_W = 32;

    // Frame decoder phases.
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,   // discarding zeros, waiting for the marker
        ST_LEN  = 2'd1,   // collecting the MSB-first length
        ST_DATA = 2'd2,   // forwarding bits to the flash
        ST_HALT = 2'd3    // transfer finished or aborted, wait for capture
    } phase_t;
endpackage

// File: rtl/jsb_frame_fsm.sv
// Module: jsb_frame_fsm
// Decodes the TDI stream of one DR shift into marker, length and data
// phases. Marks which shifted bits are SPI data bits.
// Assumes: capture, update and shift_en come from the TAP on the same
// TCK; capture and shift_en never overlap in a legal TAP sequence.
module jsb_frame_fsm
    import jsb_pkg::*;
#(
    parameter int unsigned CNT_W = LEN_W
) (
    input  logic tck,
    input  logic rst_n,
    input  logic shift_en,
    input  logic capture,
    input  logic update,
    input  logic tdi,
    output logic take_bit,
    output phase_t phase
);
    localparam int unsigned IDX_W = $clog2(CNT_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CNT_W - 1);

    logic [CNT_W-1:0] len_sr;
    logic [IDX_W-1:0] len_idx;
    logic [CNT_W-1:0] remain;
    logic             shifting;

    // Purpose: a bit is really being shifted this cycle.
    assign shifting = shift_en && !capture && !update;

    // Purpose: the current TDI bit belongs to the SPI data stream.
    assign take_bit = shifting && (phase == ST_DATA);

    // Purpose: phase sequencing, length capture and data countdown.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            phase   <= ST_HUNT;
            len_sr  <= '0;
            len_idx <= '0;
            remain  <= '0;
        end else if (capture) begin
            phase   <= ST_HUNT;
            len_idx <= '0;
        end else if (shifting) begin
            unique case (phase)
                ST_HUNT: begin
                    if (tdi) begin
                        phase   <= ST_LEN;
                        len_idx <= '0;
                    end
                end
                ST_LEN: begin
                    len_sr  <= {len_sr[CNT_W-2:0], tdi};
                    len_idx <= len_idx + 1'b1;
                    if (len_idx == IDX_LAST) begin
                        phase  <= ST_DATA;
                        remain <= {len_sr[CNT_W-2:0], tdi};
                    end
                end
                ST_DATA: begin
                    if (remain == '0) phase <= ST_HALT;
                    else              remain <= remain - 1'b1;
                end
                default: phase <= ST_HALT;
            endcase
        end else if (phase == ST_LEN || phase == ST_DATA) begin
            phase <= ST_HALT;   // left Shift-DR mid-frame: abort
        end
    end

    // Zeros while hunting keep the decoder hunting (R2).
    assert_hunt_zero_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (phase == ST_HUNT && shift_en && !tdi) |=> phase == ST_HUNT)
        else $error("hunt left on zero bit");

    // The data phase is only entered from the length phase (R3).
    assert_len_before_data_R3: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(phase == ST_DATA) |-> $past(phase) == ST_LEN)
        else $error("data phase entered without length");

    // Capture always re-arms marker hunting (R9).
    assert_capture_rearm_R9: assert property (@(posedge tck) disable iff (!rst_n)
        capture |=> phase == ST_HUNT)
        else $error("capture did not re-arm");
endmodule

// File: rtl/jsb_spi_drive.sv
// Module: jsb_spi_drive
// Registers chip select and MOSI for each data bit and gates an SCK
// pulse into the low half of the following TCK cycle. The flash
// samples MOSI on the SCK rise and shifts MISO on the SCK fall.
// Assumes: take_bit is produced from TCK-rising-edge registers.
module jsb_spi_drive (
    input  logic tck,
    input  logic rst_n,
    input  logic take_bit,
    input  logic tdi,
    output logic spi_sck,
    output logic spi_cs_n,
    output logic spi_mosi
);
    logic sck_en;

    // Purpose: latch the SPI pin state for the bit taken on this edge.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            spi_cs_n <= 1'b1;
            spi_mosi <= 1'b0;
            sck_en   <= 1'b0;
        end else begin
            spi_cs_n <= !take_bit;
            sck_en   <= take_bit;
            if (take_bit) spi_mosi <= tdi;
        end
    end

    // Purpose: a glitch-free clock pulse while TCK is low.
    assign spi_sck = sck_en & ~tck;

    // An SCK pulse is only armed inside the chip-select window (R5).
    assert_sck_in_cs_R5: assert property (@(posedge tck) disable iff (!rst_n)
        sck_en |-> !spi_cs_n)
        else $error("sck armed with cs high");
endmodule

// File: rtl/jsb_tdo_return.sv
// Module: jsb_tdo_return
// One-stage register returning flash MISO on TDO. The single stage gives
// the fixed one-TCK latency that a one-device chain expects.
module jsb_tdo_return (
    input  logic tck,
    input  logic rst_n,
    input  logic shift_en,
    input  logic spi_miso,
    output logic tdo
);
    // Purpose: sample MISO at the end of each SCK pulse while shifting.
    always_ff @(posedge tck) begin
        if (!rst_n)        tdo <= 1'b0;
        else if (shift_en) tdo <= spi_miso;
    end
endmodule

// File: rtl/jtag_spi_bridge.sv
// Module: jtag_spi_bridge (top)
// Turns one Shift-DR pass of a user data register into one SPI flash
// transaction: marker, 32-bit length, then length+1 data bits.
// Assumes: TAP control strobes are synchronous to tck; single-device chain.
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int unsigned CNT_W = LEN_W
) (
    input  logic tck,
    input  logic rst_n,
    input  logic shift_en,
    input  logic capture,
    input  logic update,
    input  logic tdi,
    output logic tdo,
    output logic spi_sck,
    output logic spi_cs_n,
    output logic spi_mosi,
    input  logic spi_miso
);
    logic   take_bit;
    phase_t phase;

    jsb_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
        .tck      (tck),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .capture  (capture),
        .update   (update),
        .tdi      (tdi),
        .take_bit (take_bit),
        .phase    (phase)
    );

    jsb_spi_drive u_drive (
        .tck      (tck),
        .rst_n    (rst_n),
        .take_bit (take_bit),
        .tdi      (tdi),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi)
    );

    jsb_tdo_return u_tdo (
        .tck      (tck),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .spi_miso (spi_miso),
        .tdo      (tdo)
    );

    // Chip select only drops after a shifting cycle (R8).
    assert_cs_needs_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
        !spi_cs_n |-> $past(shift_en))
        else $error("cs low without shift");

    // Update ends the transfer (R10).
    assert_update_release_R10: assert property (@(posedge tck) disable iff (!rst_n)
        update |=> spi_cs_n)
        else $error("cs low after update");
endmodule

// File: tb/jtag_spi_bridge_test.sv
module jtag_spi_bridge_test;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0, capture = 1'b0, update = 1'b0, tdi = 1'b0;
    logic tdo, spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 tck = ~tck;

    jtag_spi_bridge uut (
        .tck(tck), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
        .update(update), .tdi(tdi), .tdo(tdo), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Flash model: presents pattern bit k during SCK pulse k.
    logic [63:0] pat;
    int          fk = 0;
    always @(posedge spi_sck) begin
        spi_miso = pat[fk];
        fk++;
    end
    always @(posedge spi_cs_n) fk = 0;

    typedef struct {
        longint due;
        bit     ck_cs, ck_sck, ck_mosi, ck_tdo;
        logic   cs, sck, mosi, td;
        string  rcs, rsck;
    } exp_t;
    exp_t q[$];

    task automatic check(input string req, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, expv, $time);
        end
    endtask

    // Monitor: compare outputs shortly after each falling edge.
    always begin
        @(negedge tck);
        #2;
        while (q.size() > 0 && q[0].due <= $time) begin
            exp_t e;
            e = q.pop_front();
            if (e.ck_cs)   check(e.rcs, "spi_cs_n", spi_cs_n, e.cs);
            if (e.ck_sck)  check(e.rsck, "spi_sck", spi_sck, e.sck);
            if (e.ck_mosi) check("R4", "spi_mosi", spi_mosi, e.mosi);
            if (e.ck_tdo)  check("R7", "tdo", tdo, e.td);
        end
    end

    // Driver: apply one TCK of TAP inputs and queue the result expected after it.
    task automatic step(input logic sh, input logic d, input logic cp, input logic up,
                        input exp_t e);
        @(negedge tck);
        shift_en = sh; tdi = d; capture = cp; update = up;
        e.due = $time + 12;
        q.push_back(e);
    endtask

    task automatic run_frame(input int lead, input int cnt, input int extra,
                             input logic [63:0] data, input logic [63:0] miso_pat,
                             input int abort_at);
        exp_t e;
        int npos;
        pat = miso_pat;
        e = '{due: 0, ck_cs: 1, ck_sck: 1, ck_mosi: 0, ck_tdo: 0,
               cs: 1, sck: 0, mosi: 0, td: 0, rcs: "R9", rsck: "R9"};
        step(0, 0, 1, 0, e);                     // capture: re-arm
        npos = (abort_at >= 0) ? lead + 33 + abort_at : lead + 33 + cnt + 1 + extra;
        for (int p = 0; p < npos; p++) begin
            logic b;
            int d;
            d = p - (lead + 33);
            if (p < lead)            b = 1'b0;
            else if (p == lead)      b = 1'b1;
            else if (d < 0)          b = cnt[31 - (p - lead - 1)];
            else if (d <= cnt)       b = data[cnt - d];
            else                     b = 1'b1;
            e = '{due: 0, ck_cs: 1, ck_sck: 1, ck_mosi: 0, ck_tdo: 0,
                   cs: 1, sck: 0, mosi: 0, td: 0, rcs: "R3", rsck: "R3"};
            if (p < lead) begin e.rcs = "R2"; e.rsck = "R2"; end
            if (d >= 0 && d <= cnt) begin
                e.cs = 0; e.sck = 1; e.ck_mosi = 1; e.mosi = b;
                e.rcs = "R4"; e.rsck = "R5";
            end else if (d > cnt) begin
                e.rcs = "R6"; e.rsck = "R6";
            end
            if (d >= 1 && d - 1 <= cnt) begin e.ck_tdo = 1; e.td = miso_pat[d - 1]; end
            step(1, b, 0, 0, e);
        end
        if (abort_at >= 0) begin
            e = '{due: 0, ck_cs: 1, ck_sck: 1, ck_mosi: 0, ck_tdo: 0,
                   cs: 1, sck: 0, mosi: 0, td: 0, rcs: "R10", rsck: "R10"};
            step(0, 0, 0, 1, e);                 // update while transfer pending
            for (int k = 0; k < 6; k++) begin
                e.rcs = "R8"; e.rsck = "R8";
                step(1, 1, 0, 0, e);             // further shifting is ignored
            end
        end
        e = '{due: 0, ck_cs: 1, ck_sck: 1, ck_mosi: 0, ck_tdo: 0,
               cs: 1, sck: 0, mosi: 0, td: 0, rcs: "R6", rsck: "R6"};
        step(0, 0, 0, 1, e);
        step(0, 0, 0, 0, e);
    endtask

    initial begin
        repeat (3) @(negedge tck);
        #2;
        check("R1", "spi_cs_n", spi_cs_n, 1'b1);
        check("R1", "spi_sck", spi_sck, 1'b0);
        check("R1", "spi_mosi", spi_mosi, 1'b0);
        check("R1", "tdo", tdo, 1'b0);
        @(negedge tck);
        rst_n = 1'b1;
        run_frame(3, 15, 4, 64'hA53C, 64'h0000_0000_0000_C1E7, -1);
        run_frame(0, 7, 2, 64'h9F, 64'h0000_0000_0000_0036, -1);
        run_frame(1, 0, 2, 64'h1, 64'h1, -1);
        run_frame(2, 40, 0, 64'h0123_4567_89AB, 64'hFFFF_FFFF_FFFF, 10);
        run_frame(0, 23, 3, 64'h5A_F00D, 64'h0000_0000_00B4_E92D, -1);
        repeat (3) @(negedge tck);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule